// File: doc/BRIEF.md
# Performance Counter Gating Controller

This block holds one 32-bit mode-control register and a set of event counters (two by default). Software reaches all of them through a special-purpose-register access port. Each access carries a valid strobe, a write/read select, an address, write data and a flag that marks the requester as running in user mode. Reads are combinational. Writes take effect at the next clock edge.

On every cycle the block decides whether hardware may change the counters. It combines five hold bits in the control register with two processor-state inputs:
- a problem-state bit, where 1 means user state;
- a performance-mark bit.

When counting is allowed, each counter advances by one on a cycle where its event input is high. A counter whose most significant bit turns from 0 to 1 through an increment raises a one-cycle interrupt request, provided the interrupt-arm bit is set. Hardware then clears the arm bit, so software must set it again to re-arm.

Top module: `pmon_gate_ctrl`

## Requirements
- R1: After reset the control register and every counter read as 0, and `irq_o` and `priv_err_o` are both 0.
- R2: A supervisor write (`spr_user`=0) to address 952 stores all 32 data bits in the control register. A read of address 952 returns that value, and repeated reads do not change it.
- R3: Address 936 returns the control register to reads in either mode and is never written. The following are ignored and make `priv_err_o` high for one cycle, in the cycle after the access: a write to 936, and any access from user mode to 952 or to a counter address. A user-mode read of 952 or a counter address returns 0.
- R4: When control bit 31 (global hold) is 1, no counter changes on an event.
- R5: When control bit 30 is 1 and `msr_pr`=0, no counter changes on an event.
- R6: When control bit 29 is 1 and `msr_pr`=1, no counter changes on an event.
- R7: When control bit 28 is 1 and `msr_pm`=1, no counter changes on an event. When control bit 27 is 1 and `msr_pm`=0, no counter changes on an event.
- R8: If no hold condition of R4 to R7 applies, counter i (read at address 953+i) increases by exactly one on each cycle where `ev_in[i]` is 1. The counters run independently.
- R9: A supervisor write to a counter address loads that counter. In a cycle where both happen, the write takes precedence over an event.
- R10: If an increment turns a counter's bit 31 from 0 to 1 while control bit 26 (interrupt arm) is 1, `irq_o` is 1 in the next cycle for exactly one cycle. From that same cycle, control bit 26 reads 0.
- R11: While control bit 26 is 0, an overflow does not raise `irq_o`. Once software sets bit 26 again, the next overflow raises it.
- R12: A software write that sets a counter's bit 31 does not raise `irq_o`, and control bit 26 stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spr_valid | input | 1 | Access strobe |
| spr_wr | input | 1 | 1 = write, 0 = read |
| spr_user | input | 1 | 1 = access issued from user mode |
| spr_addr | input | 10 | Register address |
| spr_wdata | input | 32 | Write data |
| spr_rdata | output | 32 | Read data, combinational, 0 when no read hits |
| msr_pr | input | 1 | Problem state: 1 = user, 0 = supervisor |
| msr_pm | input | 1 | Performance-mark state |
| ev_in | input | 2 | One event pulse per counter |
| irq_o | output | 1 | Interrupt request pulse |
| priv_err_o | output | 1 | Rejected-access pulse |

## Verification
Read data is combinational, so it is compared in the same cycle the read is driven. Counter and control-register updates are checked by a read issued one cycle after the write or event. `priv_err_o` and `irq_o` are each registered once, so the driver queues their expected values with a due cycle one later than the causing access or increment. It also queues `irq_o`=0 for the cycle after that, to confirm the pulse lasts one cycle. The monitor samples at the falling edge and compares each queued item only when its due cycle comes up, so every result is checked in exactly the cycle it is due.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
   // Bit positions inside the 32-bit mode-control register
   localparam int CTL_W        = 32;
   localparam int IDX_HOLD_ALL = 31;
   localparam int IDX_HOLD_SUP = 30;
   localparam int IDX_HOLD_USR = 29;
   localparam int IDX_HOLD_MK1 = 28;
   localparam int IDX_HOLD_MK0 = 27;
   localparam int IDX_IRQ_ARM  = 26;

   typedef struct packed {
      logic all;
      logic sup;
      logic usr;
      logic mk1;
      logic mk0;
   } hold_cfg_t;

   function automatic hold_cfg_t cfg_from_ctl(input logic [CTL_W-1:0] c);
      hold_cfg_t h;
      h.all = c[IDX_HOLD_ALL];
      h.sup = c[IDX_HOLD_SUP];
      h.usr = c[IDX_HOLD_USR];
      h.mk1 = c[IDX_HOLD_MK1];
      h.mk0 = c[IDX_HOLD_MK0];
      return h;
   endfunction
endpackage

// File: rtl/pmon_ctl_reg.sv
module pmon_ctl_reg
   import pmon_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [CTL_W-1:0] wr_data_i,
   input  logic             fire_i,
   output logic [CTL_W-1:0] ctl_q
);
   localparam logic [CTL_W-1:0] ARM_MASK = CTL_W'(1) << IDX_IRQ_ARM;

   logic [CTL_W-1:0] ctl_d;

   always_comb begin
      ctl_d = ctl_q;
      if (wr_en_i) ctl_d = wr_data_i;
      // hardware disarm wins over a concurrent software write
      if (fire_i)  ctl_d = ctl_d & ~ARM_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q <= '0;
      else        ctl_q <= ctl_d;
   end

   AST_DISARM_ON_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |=> !ctl_q[IDX_IRQ_ARM]);                                       // R10
   AST_CTL_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> ((ctl_q | ARM_MASK) == ($past(ctl_q) | ARM_MASK)));       // R3
endmodule

// File: rtl/pmon_freeze.sv
module pmon_freeze
   import pmon_pkg::*;
(
   input  hold_cfg_t cfg_i,
   input  logic      pr_i,
   input  logic      pm_i,
   output logic      frozen_o
);
   logic by_state, by_mark;

   always_comb begin
      by_state = (cfg_i.sup & ~pr_i) | (cfg_i.usr & pr_i);
      by_mark  = (cfg_i.mk1 & pm_i)  | (cfg_i.mk0 & ~pm_i);
      frozen_o = cfg_i.all | by_state | by_mark;
   end
endmodule

// File: rtl/pmon_counter.sv
module pmon_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en_i,
   input  logic [W-1:0] wr_data_i,
   input  logic         ev_i,
   input  logic         frozen_i,
   output logic [W-1:0] cnt_q,
   output logic         rise_o
);
   logic         inc;
   logic [W-1:0] nxt;

   always_comb begin
      inc    = ev_i & ~frozen_i & ~wr_en_i;
      nxt    = cnt_q + W'(1);
      rise_o = inc & ~cnt_q[W-1] & nxt[W-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (wr_en_i) cnt_q <= wr_data_i;
      else if (inc)     cnt_q <= nxt;
   end

   AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen_i && !wr_en_i) |=> $stable(cnt_q));                            // R4
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i && !frozen_i && !wr_en_i) |=> (cnt_q == $past(cnt_q) + W'(1)));  // R8
   AST_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (cnt_q == $past(wr_data_i)));                              // R9
endmodule

// File: rtl/pmon_gate_ctrl.sv
module pmon_gate_ctrl
   import pmon_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int CNT_W      = 32,
   parameter int N_CNT      = 2,
   parameter int A_CTL      = 952,
   parameter int A_CTL_U    = 936,
   parameter int A_CNT_BASE = 953
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spr_valid,
   input  logic              spr_wr,
   input  logic              spr_user,
   input  logic [ADDR_W-1:0] spr_addr,
   input  logic [31:0]       spr_wdata,
   output logic [31:0]       spr_rdata,
   input  logic              msr_pr,
   input  logic              msr_pm,
   input  logic [N_CNT-1:0]  ev_in,
   output logic              irq_o,
   output logic              priv_err_o
);
   initial begin
      AST_PARAM_CNT_W: assert (CNT_W >= 2 && CNT_W <= 32);
      AST_PARAM_N_CNT: assert (N_CNT >= 1);
      AST_PARAM_ADDR:  assert (A_CTL != A_CTL_U && (A_CNT_BASE > A_CTL || A_CNT_BASE + N_CNT <= A_CTL_U));
   end

   logic [CTL_W-1:0] ctl_q;
   logic             hit_ctl, hit_alias, wr_ok, bad_acc, frozen, fire;
   logic [N_CNT-1:0] hit_cnt, rise;
   logic [CNT_W-1:0] cnt_val [N_CNT];
   logic             irq_q, err_q;

   // ---------------- address decode ----------------
   always_comb begin
      hit_ctl   = (spr_addr == ADDR_W'(A_CTL));
      hit_alias = (spr_addr == ADDR_W'(A_CTL_U));
      wr_ok     = spr_valid & spr_wr & ~spr_user;
      bad_acc   = spr_valid & ((spr_wr & hit_alias) | (spr_user & (hit_ctl | (|hit_cnt))));
   end

   pmon_ctl_reg u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_ok & hit_ctl),
      .wr_data_i (spr_wdata),
      .fire_i    (fire),
      .ctl_q     (ctl_q)
   );

   pmon_freeze u_frz (
      .cfg_i    (cfg_from_ctl(ctl_q)),
      .pr_i     (msr_pr),
      .pm_i     (msr_pm),
      .frozen_o (frozen)
   );

   for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
      assign hit_cnt[g] = (spr_addr == ADDR_W'(A_CNT_BASE + g));
      pmon_counter #(.W(CNT_W)) u_cnt (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en_i   (wr_ok & hit_cnt[g]),
         .wr_data_i (spr_wdata[CNT_W-1:0]),
         .ev_i      (ev_in[g]),
         .frozen_i  (frozen),
         .cnt_q     (cnt_val[g]),
         .rise_o    (rise[g])
      );
   end

   // ---------------- read path ----------------
   always_comb begin
      spr_rdata = '0;
      if (spr_valid && !spr_wr) begin
         if (hit_alias || (hit_ctl && !spr_user)) spr_rdata = ctl_q;
         for (int i = 0; i < N_CNT; i++)
            if (hit_cnt[i] && !spr_user) spr_rdata = 32'(cnt_val[i]);
      end
   end

   // ---------------- interrupt and error pulses ----------------
   assign fire = ctl_q[IDX_IRQ_ARM] & (|rise);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         irq_q <= fire;
         err_q <= bad_acc;
      end
   end

   assign irq_o      = irq_q;
   assign priv_err_o = err_q;

   AST_IRQ_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);                                                     // R10
   AST_IRQ_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> !ctl_q[IDX_IRQ_ARM]);                                        // R11
   AST_ERR_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      priv_err_o |-> $past(spr_valid));                                      // R3
endmodule

// File: tb/sim_pmon_gate_ctrl.sv
`timescale 1ns/1ps
module sim_pmon_gate_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spr_valid = 1'b0, spr_wr = 1'b0, spr_user = 1'b0;
   logic [9:0]  spr_addr = '0;
   logic [31:0] spr_wdata = '0;
   logic [31:0] spr_rdata;
   logic        msr_pr = 1'b0, msr_pm = 1'b0;
   logic [1:0]  ev_in = '0;
   logic        irq_o, priv_err_o;

   always #2.5 clk = ~clk;

   pmon_gate_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .spr_valid(spr_valid), .spr_wr(spr_wr),
      .spr_user(spr_user), .spr_addr(spr_addr), .spr_wdata(spr_wdata),
      .spr_rdata(spr_rdata), .msr_pr(msr_pr), .msr_pm(msr_pm),
      .ev_in(ev_in), .irq_o(irq_o), .priv_err_o(priv_err_o)
   );

   localparam int A_CTL = 952, A_ALIAS = 936, A_C0 = 953, A_C1 = 954;
   localparam logic [31:0] ARM = 32'h0400_0000;   // bit 26

   typedef struct {
      int          due;
      int          sel;   // 0 rdata, 1 irq_o, 2 priv_err_o
      logic [31:0] exp;
      string       req;
   } item_t;

   item_t q[$];
   int    cyc = 0;
   int    n_chk = 0, n_err = 0;
   bit    done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // ---------------- monitor ----------------
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].due <= cyc) begin
         item_t it;
         logic [31:0] act;
         it  = q.pop_front();
         act = (it.sel == 0) ? spr_rdata : (it.sel == 1) ? {31'b0, irq_o} : {31'b0, priv_err_o};
         n_chk++;
         if (act !== it.exp || it.due != cyc) begin
            n_err++;
            $display("FAIL %s sel=%0d cycle=%0d actual=%h expected=%h", it.req, it.sel, cyc, act, it.exp);
         end
      end
   end

   // ---------------- driver ----------------
   task automatic push(int delay, int sel, logic [31:0] exp, string req);
      item_t it;
      it.due = cyc + delay; it.sel = sel; it.exp = exp; it.req = req;
      q.push_back(it);
   endtask

   task automatic drv(bit v, bit w, bit u, int a, logic [31:0] d, logic [1:0] e);
      @(posedge clk); #1;
      spr_valid = v; spr_wr = w; spr_user = u;
      spr_addr = 10'(a); spr_wdata = d; ev_in = e;
   endtask

   task automatic idle();                        drv(0, 0, 0, 0, 0, 2'b00); endtask
   task automatic wr(int a, logic [31:0] d);     drv(1, 1, 0, a, d, 2'b00); endtask
   task automatic ev(logic [1:0] e);             drv(0, 0, 0, 0, 0, e);     endtask
   task automatic rd(int a, bit u, logic [31:0] exp, string req);
      drv(1, 0, u, a, 0, 2'b00);
      push(0, 0, exp, req);
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;

      // R1: reset state
      rd(A_CTL, 0, 32'h0, "R1");
      push(0, 1, 0, "R1");
      push(0, 2, 0, "R1");
      rd(A_C0, 0, 32'h0, "R1");
      rd(A_C1, 0, 32'h0, "R1");

      // R2: supervisor write and side-effect-free reads
      wr(A_CTL, 32'hA5A5_1234);
      rd(A_CTL, 0, 32'hA5A5_1234, "R2");
      push(1, 2, 0, "R2");
      rd(A_CTL, 0, 32'hA5A5_1234, "R2");

      // R3: alias, rejected writes, user reads of supervisor space
      rd(A_ALIAS, 1, 32'hA5A5_1234, "R3");
      drv(1, 1, 1, A_CTL, 32'hFFFF_FFFF, 2'b00);
      push(1, 2, 1, "R3");
      rd(A_CTL, 0, 32'hA5A5_1234, "R3");
      push(1, 2, 0, "R3");
      drv(1, 1, 0, A_ALIAS, 32'h0, 2'b00);
      push(1, 2, 1, "R3");
      rd(A_ALIAS, 0, 32'hA5A5_1234, "R3");
      rd(A_C0, 1, 32'h0, "R3");
      push(1, 2, 1, "R3");
      drv(1, 1, 1, A_C1, 32'h55, 2'b00);
      push(1, 2, 1, "R3");
      wr(A_CTL, 32'h0);
      rd(A_C1, 0, 32'h0, "R3");

      // R4..R7 / R8: every hold-bit combination against both state inputs
      for (int combo = 0; combo < 32; combo++) begin
         for (int st = 0; st < 4; st++) begin
            bit b0, b1, b2, b3, b4, pr, pm, fz;
            string why;
            b0 = combo[4]; b1 = combo[3]; b2 = combo[2]; b3 = combo[1]; b4 = combo[0];
            pr = st[0]; pm = st[1];
            wr(A_CTL, 32'(combo) << 27);
            wr(A_C0, 32'h0);
            msr_pr = pr; msr_pm = pm;
            ev(2'b01);
            why = "R8";
            if (b3 && pm)       why = "R7";
            if (b4 && !pm)      why = "R7";
            if (b2 && pr)       why = "R6";
            if (b1 && !pr)      why = "R5";
            if (b0)             why = "R4";
            fz = b0 | (b1 & !pr) | (b2 & pr) | (b3 & pm) | (b4 & !pm);
            rd(A_C0, 0, fz ? 32'h0 : 32'h1, why);
         end
      end
      msr_pr = 0; msr_pm = 0;

      // R8: independent counters
      wr(A_CTL, 32'h0);
      wr(A_C0, 32'h0);
      wr(A_C1, 32'h0);
      ev(2'b11); ev(2'b11); ev(2'b11);
      ev(2'b10); ev(2'b10);
      idle();
      rd(A_C0, 0, 32'd3, "R8");
      rd(A_C1, 0, 32'd5, "R8");

      // R9: software write beats an event in the same cycle
      drv(1, 1, 0, A_C0, 32'd77, 2'b01);
      rd(A_C0, 0, 32'd77, "R9");

      // R10: overflow while armed
      wr(A_CTL, ARM);
      wr(A_C0, 32'h7FFF_FFFF);
      ev(2'b01);
      push(1, 1, 1, "R10");
      push(2, 1, 0, "R10");
      idle();
      rd(A_CTL, 0, 32'h0, "R10");
      rd(A_C0, 0, 32'h8000_0000, "R10");

      // R11: disarmed overflow is silent, re-arm works
      wr(A_C1, 32'h7FFF_FFFF);
      ev(2'b10);
      push(1, 1, 0, "R11");
      idle();
      rd(A_C1, 0, 32'h8000_0000, "R11");
      wr(A_CTL, ARM);
      wr(A_C0, 32'h7FFF_FFFF);
      ev(2'b01);
      push(1, 1, 1, "R11");
      idle();
      rd(A_CTL, 0, 32'h0, "R11");

      // R12: software write setting bit 31 does not fire
      wr(A_CTL, ARM);
      wr(A_C0, 32'h8000_0000);
      push(1, 1, 0, "R12");
      idle();
      rd(A_CTL, 0, ARM, "R12");

      repeat (4) idle();
      if (q.size() != 0) begin
         n_chk++; n_err++;
         $display("FAIL queue actual=%0d expected=0", q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      done = 1;
      $finish;
   end
endmodule